// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block produces the interrupt logic for one bank of general-purpose input pins. Every cycle it samples each pin. Three per-pin configuration words decide what counts as an event: the trigger kind (edge or level), the sense (rising/high or falling/low) and a both-edges selector. Detected events are latched in a sticky status word, and software clears that word by writing ones to it.

A mask word decides which pending status bits may reach the single combined interrupt line. Masking blocks only that path. Detection and capture go on while a pin is masked, so a pin that is unmasked with a stale status bit fires at once unless software clears the bit first. The mask has no direct write. One write-one port clears mask bits and another sets them, and a read-only view shows the current mask.

The pins are expected to be synchronised before they reach the block. Access is through a plain 32-bit register port: a write strobe with an address and data, and read data that follows the address combinationally. There is no data stream at the boundary, so the port has no valid/ready handshake and never stalls.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mask bit reads 1 (pin masked), and the status, kind, sense and both-edges words read 0. `irq_o` is 0.
- R2: Writing to the unmask port (address 0x08, write-only, reads 0) clears each mask bit whose data bit is 1. Bits written 0 leave the mask unchanged.
- R3: Writing to the mask-set port (address 0x0C, write-only, reads 0) sets each mask bit whose data bit is 1. Bits written 0 leave the mask unchanged. The current mask reads at address 0x04, where 1 means masked.
- R4: With kind bit 1 (edge) and both-edges bit 0, a pin sets its status bit on a rising edge when the sense bit is 1 and on a falling edge when the sense bit is 0. An edge is a difference between the current sample and the sample taken one clock earlier.
- R5: With kind bit 1 and both-edges bit 1, either edge sets the status bit, whatever the sense bit holds.
- R6: With kind bit 0 (level), the status bit sets in every cycle in which the pin equals its sense bit, and the both-edges bit has no effect. After a clear, the bit sets again one cycle later if the level is still present.
- R7: Status (address 0x00) is cleared bit by bit by writing 1s. Bits written 0 are untouched. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Status bits are captured while masked. `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R9: The kind (0x10), sense (0x14) and both-edges (0x18) words read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Synchronised pin samples |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Byte address of the register |
| reg_wdata_i | input | NPIN | Write data |
| reg_rdata_o | output | NPIN | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets a pending bit left from a masked period. A design that gated capture with the mask would keep `irq_o` low after the unmask, and the bench would catch it. A clear that lands in the same cycle as a level or edge event must leave the bit set; a design that gave the clear priority would lose that event. Both-edges mode is run with the sense bit at both values, and level mode is run with the both-edges bit set. A design that decoded those selectors in the wrong precedence would miss edges or latch spurious events. Random pin traffic and register writes are also compared cycle by cycle against a bench model of the status, the mask and the interrupt line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 5;
  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS  = 5'h00,
    RA_MASK    = 5'h04,
    RA_UNMASK  = 5'h08,
    RA_MASKSET = 5'h0C,
    RA_KIND    = 5'h10,
    RA_SENSE   = 5'h14,
    RA_BOTH    = 5'h18
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   kind_o,
  output logic [NPIN-1:0]   sense_o,
  output logic [NPIN-1:0]   both_o,
  output logic [NPIN-1:0]   mask_o
);
  logic wr_kind, wr_sense, wr_both, wr_unmask, wr_maskset;

  always_comb begin
    wr_kind    = wr_i && (addr_i == RA_KIND);
    wr_sense   = wr_i && (addr_i == RA_SENSE);
    wr_both    = wr_i && (addr_i == RA_BOTH);
    wr_unmask  = wr_i && (addr_i == RA_UNMASK);
    wr_maskset = wr_i && (addr_i == RA_MASKSET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_o  <= '0;
      sense_o <= '0;
      both_o  <= '0;
      mask_o  <= '1;
    end else begin
      if (wr_kind)    kind_o  <= wdata_i;
      if (wr_sense)   sense_o <= wdata_i;
      if (wr_both)    both_o  <= wdata_i;
      if (wr_unmask)  mask_o  <= mask_o & ~wdata_i;
      if (wr_maskset) mask_o  <= mask_o | wdata_i;
    end
  end

  a_r2_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask_o & $past(wdata_i)) == '0));
  a_r3_maskset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_maskset |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_unmask && !wr_maskset) |=> $stable(mask_o));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] kind_i,
  input  logic [NPIN-1:0] sense_i,
  input  logic [NPIN-1:0] both_i,
  output logic [NPIN-1:0] evt_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    always_comb begin
      rise      = pin_i[g] & ~prev_q[g];
      fall      = ~pin_i[g] & prev_q[g];
      edge_hit  = both_i[g] ? (rise | fall) : (sense_i[g] ? rise : fall);
      level_hit = (pin_i[g] == sense_i[g]);
      evt_o[g]  = kind_i[g] ? edge_hit : level_hit;
    end

    a_r5_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i[g] && both_i[g] && (pin_i[g] != $past(pin_i[g]))) |-> evt_o[g]);
    a_r4_no_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i[g] && (pin_i[g] == $past(pin_i[g]))) |-> !evt_o[g]);
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] evt_i,
  input  logic [NPIN-1:0] clr_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [NPIN-1:0] status_o,
  output logic            irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_i) | evt_i;
  end

  assign irq_o = |(status_o & ~mask_i);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));
  a_r7_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0 && evt_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [NPIN-1:0] reg_wdata_i,
  output logic [NPIN-1:0] reg_rdata_o,
  output logic            irq_o
);
  logic [NPIN-1:0] kind, sense, both, mask, evt, status, clr;

  gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .kind_o(kind), .sense_o(sense), .both_o(both),
    .mask_o(mask)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .kind_i(kind),
    .sense_i(sense), .both_i(both), .evt_o(evt)
  );

  assign clr = (reg_wr_i && reg_addr_i == RA_STATUS) ? reg_wdata_i : '0;

  gpio_irq_status #(.NPIN(NPIN)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .mask_i(mask),
    .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      RA_STATUS: reg_rdata_o = status;
      RA_MASK:   reg_rdata_o = mask;
      RA_KIND:   reg_rdata_o = kind;
      RA_SENSE:  reg_rdata_o = sense;
      RA_BOTH:   reg_rdata_o = both;
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq_o);
  a_r8_unmasked_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask) != '0) |-> irq_o);
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  localparam int N = 32;
  localparam logic [4:0] A_STS = 5'h00, A_MSK = 5'h04, A_UNM = 5'h08,
                         A_MST = 5'h0C, A_KND = 5'h10, A_SNS = 5'h14, A_BTH = 5'h18;

  logic clk = 0, rst_n = 0, wr = 0, irq;
  logic [4:0] addr = A_STS;
  logic [N-1:0] pins = '1, wdata = '0, rdata;
  int checks = 0, fails = 0;

  logic [N-1:0] m_kind, m_sense, m_both, m_mask, m_sts, m_prev;

  always #10 clk = ~clk;

  gpio_irq_unit #(.NPIN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [N-1:0] model_evt(logic [N-1:0] p);
    logic [N-1:0] r, f;
    r = p & ~m_prev;
    f = ~p & m_prev;
    return (m_kind & ((m_both & (r | f)) | (~m_both & ((m_sense & r) | (~m_sense & f)))))
         | (~m_kind & ~(p ^ m_sense));
  endfunction

  function automatic logic [N-1:0] model_read(logic [4:0] a);
    case (a)
      A_STS: return m_sts;
      A_MSK: return m_mask;
      A_KND: return m_kind;
      A_SNS: return m_sense;
      A_BTH: return m_both;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, string req);
    wr = 0; addr = a; #1;
    check(req, rdata, model_read(a));
  endtask

  task automatic step(logic w, logic [4:0] a, logic [N-1:0] d, logic [N-1:0] p);
    logic [N-1:0] e;
    wr = w; addr = a; wdata = d; pins = p;
    @(posedge clk);
    e = model_evt(p);
    m_sts = (m_sts & ~((w && a == A_STS) ? d : '0)) | e;
    if (w) case (a)
      A_UNM: m_mask = m_mask & ~d;
      A_MST: m_mask = m_mask | d;
      A_KND: m_kind = d;
      A_SNS: m_sense = d;
      A_BTH: m_both = d;
      default: ;
    endcase
    m_prev = p;
    @(negedge clk);
    wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] p;
    m_kind = '0; m_sense = '0; m_both = '0; m_mask = '1; m_sts = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_MSK, "R1"); check("R1", rdata, '1);
    rd(A_KND, "R1"); rd(A_SNS, "R1"); rd(A_BTH, "R1");
    rd(A_STS, "R1"); check("R1", rdata, '0);
    check("R1", {31'd0, irq}, '0);

    // R4 single edges: low half rising, high half falling
    step(1, A_KND, '1, '1);
    step(1, A_SNS, 32'h0000_FFFF, '1);
    step(1, A_STS, '1, '1);
    step(0, A_STS, '0, 32'h0000_FFFE);
    rd(A_STS, "R4"); check("R4", rdata, 32'hFFFF_0000);
    step(1, A_STS, '1, 32'h0000_FFFF);
    rd(A_STS, "R4"); check("R4", rdata, 32'h0000_0001);

    // R5 both edges, sense ignored on pin 0 (sense 1) and pin 31 (sense 0)
    step(1, A_BTH, 32'h8000_0001, 32'h0000_FFFF);
    step(1, A_STS, '1, 32'h0000_FFFF);
    step(0, A_STS, '0, 32'h8000_FFFE);
    rd(A_STS, "R5"); check("R5", rdata, 32'h8000_0001);
    step(1, A_STS, '1, 32'h0000_FFFF);
    rd(A_STS, "R5"); check("R5", rdata, 32'h8000_0001);

    // R6 level with both-edges bit set; re-set after clear
    step(1, A_KND, 32'hFFFF_FFFE, 32'h0000_FFFF);
    step(1, A_STS, '1, 32'h0000_FFFF);
    rd(A_STS, "R6"); check("R6", rdata & 32'h1, 32'h1);
    step(1, A_STS, 32'h1, 32'h0000_FFFF);
    rd(A_STS, "R7"); check("R7", rdata & 32'h1, 32'h1);
    step(1, A_STS, 32'h1, 32'h0000_FFFE);
    rd(A_STS, "R7"); check("R7", rdata & 32'h1, 32'h0);
    step(0, A_STS, '0, 32'h0000_FFFF);
    rd(A_STS, "R6"); check("R6", rdata & 32'h1, 32'h1);

    // R8 capture while masked, irq after unmask
    check("R8", {31'd0, irq}, '0);
    step(1, A_UNM, 32'h1, 32'h0000_FFFF);
    rd(A_MSK, "R2"); check("R2", rdata, 32'hFFFF_FFFE);
    check("R8", {31'd0, irq}, 32'h1);
    step(1, A_MST, 32'h1, 32'h0000_FFFF);
    rd(A_MSK, "R3"); check("R3", rdata, '1);
    check("R8", {31'd0, irq}, '0);
    rd(A_UNM, "R2"); rd(A_MST, "R3");

    // R9 readback
    step(1, A_SNS, 32'hA5C3_0F96, 32'h0000_FFFF);
    rd(A_SNS, "R9"); check("R9", rdata, 32'hA5C3_0F96);
    step(1, A_BTH, 32'h1234_5678, 32'h0000_FFFF);
    rd(A_BTH, "R9");

    // random traffic against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: a = A_UNM; 1: a = A_MST; 2, 3: a = A_STS;
        4: a = A_KND; 5: a = A_SNS; 6: a = A_BTH;
        default: a = A_MSK;
      endcase
      p = (i % 3 == 0) ? $urandom() : pins ^ (32'h1 << $urandom_range(0, 31));
      step(op < 7, a, $urandom(), p);
      rd(A_STS, "R7");
      check("R8", {31'd0, irq}, {31'd0, |(m_sts & ~m_mask)});
      if (i % 50 == 0) rd(A_MSK, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule